// File: doc/BRIEF.md
# Pipelined Sliced Wide Unsigned Multiplier

This block multiplies two 254-bit unsigned integers and returns the complete 508-bit product. The second operand is cut into 27-bit slices, the last one zero-extended from its remaining 11 bits. Each slice is multiplied by the whole first operand. That row product is itself assembled from 27x27-bit leaf multipliers, sized to fit typical FPGA multiplier blocks.

The row products are registered. They are then shifted to their slice positions and reduced by two balanced adder trees, one for the lower half of the slices and one for the upper half. A final stage shifts the upper-half sum into place and adds the lower-half sum. Register boundaries separate these three stages, so the block accepts a new operand pair on every clock. A valid flag travels alongside the data through the three stages.

It is intended as the integer core of a prime-field arithmetic unit, where a modular reduction stage would follow it.

Top module: `wmul_pipe`

## Requirements
- R1: For an accepted operand pair, `out_p` equals the exact unsigned product `in_x * in_y`, all 508 bits, including operands whose set bits fall on either side of a 27-bit slice boundary (bit 26/27) or in the 11-bit top slice (bits 243 to 253).
- R2: An operand pair sampled with `in_valid` high on rising edge t appears with `out_valid` high after rising edge t+2 and not before: exactly three register stages.
- R3: Operand pairs may be presented on consecutive cycles, and each product emerges in order, one per cycle, with no stall.
- R4: A cycle with `in_valid` low produces a cycle with `out_valid` low three register stages later. Bubbles are preserved in place within a stream.
- R5: While `rst` is high on a rising edge, `out_valid` is low after that edge. Reset is synchronous and active high.
- R6: If either operand is zero, the product is zero.
- R7: With both operands all ones, the product is (2^254 - 1)^2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_x`/`in_y` as an operand pair to multiply |
| in_x | input | 254 | Multiplicand, unsigned |
| in_y | input | 254 | Multiplier, unsigned, cut into 27-bit slices |
| out_valid | output | 1 | Marks `out_p` as a product |
| out_p | output | 508 | Full unsigned product |

## Verification
The checker holds four properties on every cycle:
- `out_valid` is the input valid delayed by exactly three stages, once three post-reset cycles exist.
- Every valid product equals a reference multiplication of the operands seen three cycles earlier.
- A zero operand always yields zero.
- Reset clears the output valid.

Only the bench scenarios show the rest. They select operands that place bits on slice boundaries and in the short top slice, and use all-ones operands that produce carries through every tree level. They also run a long back-to-back stream with scattered bubbles, which shows ordering and bubble placement against an independently computed queue.

// File: rtl/wmul_pkg.sv
package wmul_pkg;
  // Ceiling division used to size slice counts.
  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction
endpackage

// File: rtl/wmul_leaf.sv
// Leaf W x W unsigned multiplier, sized for one FPGA multiplier block.
module wmul_leaf #(
  parameter int W = 27
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  assign p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
endmodule

// File: rtl/wmul_row.sv
// Wide operand times one slice: sum of shifted leaf products.
module wmul_row
  import wmul_pkg::*;
#(
  parameter int OP_W    = 254,
  parameter int SLICE_W = 27
) (
  input  logic [OP_W-1:0]         a,
  input  logic [SLICE_W-1:0]      b,
  output logic [OP_W+SLICE_W-1:0] p
);
  localparam int NA    = cdiv(OP_W, SLICE_W);
  localparam int PAD_W = NA * SLICE_W;
  localparam int RW    = OP_W + SLICE_W;

  logic [PAD_W-1:0]     a_pad;
  logic [2*SLICE_W-1:0] leaf_p [NA];

  assign a_pad = PAD_W'(a);

  for (genvar j = 0; j < NA; j++) begin : g_leaf
    wmul_leaf #(.W(SLICE_W)) u_leaf (
      .a (a_pad[j*SLICE_W +: SLICE_W]),
      .b (b),
      .p (leaf_p[j])
    );
  end

  always_comb begin
    p = '0;
    for (int j = 0; j < NA; j++) begin
      p = p + (RW'(leaf_p[j]) << (SLICE_W * j));
    end
  end
endmodule

// File: rtl/wmul_tree.sv
// Balanced binary adder tree over N leaves, padded to a power of two.
module wmul_tree #(
  parameter int W = 508,
  parameter int N = 5
) (
  input  logic [W-1:0] leaf [N],
  output logic [W-1:0] sum
);
  localparam int LV = (N > 1) ? $clog2(N) : 0;
  localparam int NP = 1 << LV;

  logic [W-1:0] node [2*NP-1];

  for (genvar i = 0; i < NP; i++) begin : g_in
    if (i < N) begin : g_used
      assign node[NP-1+i] = leaf[i];
    end else begin : g_pad
      assign node[NP-1+i] = '0;
    end
  end

  for (genvar k = 0; k < NP-1; k++) begin : g_add
    assign node[k] = node[2*k+1] + node[2*k+2];
  end

  assign sum = node[0];
endmodule

// File: rtl/wmul_pipe.sv
// Three-stage pipelined wide unsigned multiplier.
module wmul_pipe
  import wmul_pkg::*;
#(
  parameter int OP_W    = 254,
  parameter int SLICE_W = 27
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [OP_W-1:0]      in_x,
  input  logic [OP_W-1:0]      in_y,
  output logic                 out_valid,
  output logic [2*OP_W-1:0]    out_p
);
  localparam int NS     = cdiv(OP_W, SLICE_W);
  localparam int PAD_W  = NS * SLICE_W;
  localparam int PP_W   = OP_W + SLICE_W;
  localparam int PW     = 2 * OP_W;
  localparam int NLO    = (NS + 1) / 2;
  localparam int NHI    = NS - NLO;
  localparam int HI_SHF = SLICE_W * NLO;

  // Stage 1: row products, one per slice of in_y.
  logic [PAD_W-1:0] y_pad;
  logic [PP_W-1:0]  row_c [NS];
  logic [PP_W-1:0]  s1_pp [NS];
  logic             s1_v;

  assign y_pad = PAD_W'(in_y);

  for (genvar i = 0; i < NS; i++) begin : g_row
    wmul_row #(.OP_W(OP_W), .SLICE_W(SLICE_W)) u_row (
      .a (in_x),
      .b (y_pad[i*SLICE_W +: SLICE_W]),
      .p (row_c[i])
    );
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NS; i++) s1_pp[i] <= row_c[i];
    s1_v <= rst ? 1'b0 : in_valid;
  end

  // Stage 2: two half trees, each aligned to its own lowest slice.
  logic [PW-1:0] lo_leaf [NLO];
  logic [PW-1:0] hi_leaf [NHI];
  logic [PW-1:0] lo_sum, hi_sum;
  logic [PW-1:0] s2_lo, s2_hi;
  logic          s2_v;

  for (genvar i = 0; i < NLO; i++) begin : g_lo
    assign lo_leaf[i] = PW'(s1_pp[i]) << (SLICE_W * i);
  end
  for (genvar i = 0; i < NHI; i++) begin : g_hi
    assign hi_leaf[i] = PW'(s1_pp[NLO+i]) << (SLICE_W * i);
  end

  wmul_tree #(.W(PW), .N(NLO)) u_tree_lo (.leaf(lo_leaf), .sum(lo_sum));
  wmul_tree #(.W(PW), .N(NHI)) u_tree_hi (.leaf(hi_leaf), .sum(hi_sum));

  always_ff @(posedge clk) begin
    s2_lo <= lo_sum;
    s2_hi <= hi_sum;
    s2_v  <= rst ? 1'b0 : s1_v;
  end

  // Stage 3: final shift-add into the registered output.
  always_ff @(posedge clk) begin
    out_p     <= s2_lo + (s2_hi << HI_SHF);
    out_valid <= rst ? 1'b0 : s2_v;
  end
endmodule

// File: rtl/wmul_pipe_chk.sv
// Property checker bound to the multiplier top.
module wmul_pipe_chk #(
  parameter int OP_W = 254
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   in_x,
  input logic [OP_W-1:0]   in_y,
  input logic              out_valid,
  input logic [2*OP_W-1:0] out_p
);
  localparam int PW = 2 * OP_W;

  // Consecutive out-of-reset edges seen, saturating at 3.
  logic [1:0] run;
  always_ff @(posedge clk) begin
    if (rst) run <= '0;
    else if (run != 2'd3) run <= run + 2'd1;
  end

  // R2 / R4: valid is the input valid delayed by three stages.
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (run == 2'd3) |-> (out_valid == $past(in_valid, 3)));

  // R1: each valid product matches a reference multiplication.
  p_product_r1: assert property (@(posedge clk) disable iff (rst)
    (run == 2'd3 && out_valid) |->
      (out_p == (PW'($past(in_x, 3)) * PW'($past(in_y, 3)))));

  // R6: a zero operand gives a zero product.
  p_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (run == 2'd3 && out_valid &&
     ($past(in_x, 3) == '0 || $past(in_y, 3) == '0)) |-> (out_p == '0));

  // R5: reset clears the output valid.
  p_reset_r5: assert property (@(posedge clk) rst |=> !out_valid);
endmodule

bind wmul_pipe wmul_pipe_chk #(.OP_W(OP_W)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_x      (in_x),
  .in_y      (in_y),
  .out_valid (out_valid),
  .out_p     (out_p)
);

// File: tb/test_wmul_pipe.sv
`timescale 1ns/1ps
module test_wmul_pipe;
  localparam int OP_W = 254;
  localparam int PW   = 2 * OP_W;
  localparam int NST  = 40;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [OP_W-1:0] in_x = '0;
  logic [OP_W-1:0] in_y = '0;
  logic            out_valid;
  logic [PW-1:0]   out_p;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  wmul_pipe #(.OP_W(OP_W), .SLICE_W(27)) i_wmul_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
    .out_valid(out_valid), .out_p(out_p)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [PW-1:0] act, input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [OP_W-1:0] rnd_op();
    logic [255:0] w;
    w = {$urandom, $urandom, $urandom, $urandom,
         $urandom, $urandom, $urandom, $urandom};
    return w[OP_W-1:0];
  endfunction

  function automatic logic [PW-1:0] ref_mul(input logic [OP_W-1:0] a,
                                            input logic [OP_W-1:0] b);
    return PW'(a) * PW'(b);
  endfunction

  // One operand pair; checks valid timing and the product.
  task automatic one_op(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b,
                        input string req);
    logic [PW-1:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    in_valid = 1'b1; in_x = a; in_y = b;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", "valid too early", PW'(out_valid), '0);
    @(negedge clk);
    chk(out_valid == 1'b1, "R2", "valid after three stages", PW'(out_valid), PW'(1));
    chk(out_p == exp, req, "product", out_p, exp);
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", "single valid pulse", PW'(out_valid), '0);
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R5", "valid low under reset", PW'(out_valid), '0);
    rst = 1'b0; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R5", "no valid after reset", PW'(out_valid), '0);
  endtask

  task automatic t_zero();
    one_op('0, rnd_op(), "R6");
    one_op(rnd_op(), '0, "R6");
  endtask

  task automatic t_ones();
    logic [PW-1:0] exp;
    exp = (PW'(1) << PW) - (PW'(1) << (OP_W + 1)) + PW'(1);
    chk(ref_mul('1, '1) == exp, "R7", "reference identity", ref_mul('1, '1), exp);
    one_op('1, '1, "R7");
    one_op('1, OP_W'(1), "R1");
  endtask

  task automatic t_bits();
    int pa [6] = '{0, 26, 27, 253, 243, 100};
    int pb [6] = '{0, 27, 26, 253, 10, 253};
    for (int k = 0; k < 6; k++) begin
      one_op(OP_W'(1) << pa[k], OP_W'(1) << pb[k], "R1");
      chk(out_p == (PW'(1) << (pa[k] + pb[k])), "R1", "single bit position",
          out_p, PW'(1) << (pa[k] + pb[k]));
    end
  endtask

  task automatic t_random();
    for (int k = 0; k < 8; k++) one_op(rnd_op(), rnd_op(), "R1");
  endtask

  // Back-to-back stream with bubbles every seventh slot.
  task automatic t_stream();
    logic [PW-1:0] ep [NST];
    bit            ev [NST];
    logic [OP_W-1:0] a, b;
    for (int k = 0; k < NST + 3; k++) begin
      @(negedge clk);
      if (k >= 3) begin
        chk(out_valid == ev[k-3], (ev[k-3] ? "R3" : "R4"), "stream valid",
            PW'(out_valid), PW'(ev[k-3]));
        if (ev[k-3])
          chk(out_p == ep[k-3], "R3", "stream product", out_p, ep[k-3]);
      end
      if (k < NST) begin
        a = rnd_op(); b = rnd_op();
        ev[k] = (k % 7) != 3;
        ep[k] = ref_mul(a, b);
        in_valid = ev[k]; in_x = a; in_y = b;
      end else begin
        in_valid = 1'b0;
      end
    end
  endtask

  initial begin
    t_reset();
    t_zero();
    t_ones();
    t_bits();
    t_random();
    t_stream();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule